// File: doc/BRIEF.md
# Sixteen-Channel LED Sink Shift-Latch with Line-Fault Readback

This block is the digital core of a sixteen-channel constant-current LED sink driver. Display data arrives one bit per clock on a serial input and moves through a sixteen-stage shift chain. The top stage drives a serial output, so several drivers can be chained into one long string. A latch strobe copies the chain into a sixteen-bit hold register, and that register decides which channels conduct. An active-low enable input gates every channel at once. Pulse-width modulating that enable sets brightness anywhere from fully dark to fully lit.

The same two control inputs have a second use. The block watches the enable and strobe levels over five consecutive clock edges. One fixed five-edge pattern switches it into a diagnostic mode, and a different pattern switches it back. In diagnostic mode, a low enable turns every channel on and samples per-line fault flags from the output comparators. The next strobe loads one flag per channel into the shift chain, and the flags are then clocked out on the serial output. A two-bit selector, captured during the entry pattern, chooses which line condition is reported: open line, short to ground, short to the supply, or any of the three.

Top module: `led_sink_ctrl`

## Requirements
- R1: While rst_n is low, the shift chain, hold register, capture register, pattern history and mode selector are cleared. sdo is 0, all channels are off, and the block is in normal mode.
- R2: On every rising clock edge that is not a diagnostic load, the chain moves up one place and takes sdi into bit 0. sdo is chain bit 15, so the first bit shifted in appears on sdo after 16 edges (most significant bit first).
- R3: In normal mode, an edge with le high copies the chain value from before that edge into the hold register. Bit i of the hold register drives channel i.
- R4: When oe_n is high, chan_on is all zeros. In normal mode with oe_n low, chan_on equals the hold register. Toggling oe_n does not change the hold register.
- R5: Five consecutive edges with {oe_n,le} = 10, 00, 10, 11, 10 switch normal mode to diagnostic mode after the fifth edge. sdi at the fourth edge becomes selector bit 1, and sdi at the fifth edge becomes selector bit 0. The fourth edge also latches, as in R3.
- R6: Selector encoding: 00 reports open line, 01 reports short to ground, 10 reports short to the supply, and 11 reports the OR of all three flags.
- R7: In diagnostic mode, oe_n low turns on all 16 channels, and every edge with oe_n low stores the selected fault vector in the capture register.
- R8: In diagnostic mode, an edge with le high loads the capture register into the chain instead of shifting. Bit i is channel i, with 1 meaning a fault, so channel 15 appears on sdo first. The hold register does not change while in diagnostic mode.
- R9: Five consecutive edges with {oe_n,le} = 10, 00, 10, 00, 10 return diagnostic mode to normal mode. Afterwards, chan_on follows the unchanged hold register and latching works again.
- R10: A five-edge pattern that differs from the entry pattern in any step leaves the block in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| sdi | input | 1 | Serial data in |
| le | input | 1 | Latch strobe; also part of the mode pattern |
| oe_n | input | 1 | Active-low output enable; also part of the mode pattern |
| flt_open | input | 16 | Per-channel open-line flags |
| flt_gnd | input | 16 | Per-channel short-to-ground flags |
| flt_sup | input | 16 | Per-channel short-to-supply flags |
| sdo | output | 1 | Serial data out (chain bit 15) |
| chan_on | output | 16 | Per-channel sink enable |

## Verification
The assertions check on every cycle that the chain advances by one place into sdo, that a normal-mode strobe copies the chain into the hold register, and that a diagnostic strobe loads the capture register. They also check that the hold register stays still in diagnostic mode, that a high enable forces every channel off, that a low enable in diagnostic mode forces every channel on, and that a recognised pattern flips the mode on the next edge. Only the bench scenarios can show that the right fault type reaches sdo for each selector code, in the stated bit order. The same holds for a broken pattern leaving the mode alone and for the display returning intact after a diagnostic session, because these depend on multi-edge pin sequences and on a reference written independently of the design.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  // Fault type reported in diagnostic mode
  typedef enum logic [1:0] {
    SEL_OPEN = 2'b00,
    SEL_GND  = 2'b01,
    SEL_SUP  = 2'b10,
    SEL_ANY  = 2'b11
  } flt_sel_e;

  localparam int SEQ_STEPS = 5;
  localparam int PIN_BITS  = 2;  // {oe_n, le} per edge
  localparam int SEQ_BITS  = SEQ_STEPS * PIN_BITS;

  // Oldest edge in the top pair, newest in the bottom pair
  localparam logic [SEQ_BITS-1:0] ENTER_PAT = 10'b10_00_10_11_10;
  localparam logic [SEQ_BITS-1:0] EXIT_PAT  = 10'b10_00_10_00_10;

  // Selector from the two serial bits taken during entry
  function automatic flt_sel_e sel_from_bits(input logic hi, input logic lo);
    return flt_sel_e'({hi, lo});
  endfunction

endpackage

// File: rtl/led_mode_seq.sv
module led_mode_seq
  import led_drv_pkg::*;
#(
  parameter int STEPS = SEQ_STEPS,
  parameter logic [2*STEPS-1:0] ENTER = ENTER_PAT,
  parameter logic [2*STEPS-1:0] EXIT  = EXIT_PAT
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     oe_n,
  input  logic     le,
  input  logic     sdi,
  output logic     diag_q,
  output flt_sel_e sel_q,
  output logic     enter_hit,
  output logic     exit_hit
);

  localparam int HW = 2 * STEPS;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_nx;
  logic          sdi_q;

  // Window including the levels present at this edge
  assign hist_nx   = {hist_q[HW-3:0], oe_n, le};
  assign enter_hit = !diag_q && (hist_nx == ENTER);
  assign exit_hit  = diag_q && (hist_nx == EXIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      sdi_q  <= 1'b0;
      diag_q <= 1'b0;
      sel_q  <= SEL_OPEN;
    end else begin
      sdi_q  <= sdi;
      // A recognised pattern is consumed so it cannot retrigger
      hist_q <= (enter_hit || exit_hit) ? '0 : hist_nx;
      if (enter_hit) begin
        diag_q <= 1'b1;
        sel_q  <= sel_from_bits(sdi_q, sdi);
      end else if (exit_hit) begin
        diag_q <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/led_shift_chain.sv
module led_shift_chain #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sdi,
  input  logic         par_load,
  input  logic [W-1:0] par_data,
  output logic [W-1:0] shift_q,
  output logic         sdo
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (par_load) begin
      shift_q <= par_data;
    end else begin
      shift_q <= {shift_q[W-2:0], sdi};
    end
  end

  assign sdo = shift_q[W-1];

endmodule

// File: rtl/led_store_gate.sv
module led_store_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         latch_en,
  input  logic [W-1:0] shift_q,
  input  logic         oe_n,
  input  logic         force_all,
  output logic [W-1:0] store_q,
  output logic [W-1:0] chan_on
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
    end else if (latch_en) begin
      store_q <= shift_q;
    end
  end

  always_comb begin
    if (oe_n) begin
      chan_on = '0;
    end else if (force_all) begin
      chan_on = '1;
    end else begin
      chan_on = store_q;
    end
  end

endmodule

// File: rtl/led_fault_capture.sv
module led_fault_capture
  import led_drv_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap_en,
  input  flt_sel_e     sel,
  input  logic [W-1:0] f_open,
  input  logic [W-1:0] f_gnd,
  input  logic [W-1:0] f_sup,
  output logic [W-1:0] cap_q
);

  function automatic logic [W-1:0] pick(input flt_sel_e s,
                                        input logic [W-1:0] o,
                                        input logic [W-1:0] g,
                                        input logic [W-1:0] p);
    case (s)
      SEL_OPEN: return o;
      SEL_GND:  return g;
      SEL_SUP:  return p;
      default:  return o | g | p;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= '0;
    end else if (cap_en) begin
      cap_q <= pick(sel, f_open, f_gnd, f_sup);
    end
  end

endmodule

// File: rtl/led_sink_ctrl.sv
module led_sink_ctrl
  import led_drv_pkg::*;
#(
  parameter int CHANNELS = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sdi,
  input  logic                le,
  input  logic                oe_n,
  input  logic [CHANNELS-1:0] flt_open,
  input  logic [CHANNELS-1:0] flt_gnd,
  input  logic [CHANNELS-1:0] flt_sup,
  output logic                sdo,
  output logic [CHANNELS-1:0] chan_on
);

  // Named internal events for the checker
  logic                diag_q;
  flt_sel_e            sel_q;
  logic                enter_hit;
  logic                exit_hit;
  logic                store_load;
  logic                shift_load;
  logic                cap_load;
  logic [CHANNELS-1:0] shift_q;
  logic [CHANNELS-1:0] store_q;
  logic [CHANNELS-1:0] cap_q;

  assign store_load = le && !diag_q;
  assign shift_load = le && diag_q;
  assign cap_load   = !oe_n && diag_q;

  led_mode_seq #(
    .STEPS(SEQ_STEPS),
    .ENTER(ENTER_PAT),
    .EXIT (EXIT_PAT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .oe_n     (oe_n),
    .le       (le),
    .sdi      (sdi),
    .diag_q   (diag_q),
    .sel_q    (sel_q),
    .enter_hit(enter_hit),
    .exit_hit (exit_hit)
  );

  led_shift_chain #(.W(CHANNELS)) u_chain (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdi     (sdi),
    .par_load(shift_load),
    .par_data(cap_q),
    .shift_q (shift_q),
    .sdo     (sdo)
  );

  led_store_gate #(.W(CHANNELS)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_en (store_load),
    .shift_q  (shift_q),
    .oe_n     (oe_n),
    .force_all(diag_q),
    .store_q  (store_q),
    .chan_on  (chan_on)
  );

  led_fault_capture #(.W(CHANNELS)) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_en(cap_load),
    .sel   (sel_q),
    .f_open(flt_open),
    .f_gnd (flt_gnd),
    .f_sup (flt_sup),
    .cap_q (cap_q)
  );

endmodule

// File: rtl/led_sink_ctrl_chk.sv
module led_sink_ctrl_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         le,
  input logic         oe_n,
  input logic         sdo,
  input logic [W-1:0] chan_on,
  input logic         diag_q,
  input logic         enter_hit,
  input logic         exit_hit,
  input logic [W-1:0] shift_q,
  input logic [W-1:0] store_q,
  input logic [W-1:0] cap_q
);

  a_r2_chain_advance: assert property (@(posedge clk) disable iff (!rst_n)
    !(diag_q && le) |=> sdo == $past(shift_q[W-2]));

  a_r3_latch_copy: assert property (@(posedge clk) disable iff (!rst_n)
    (!diag_q && le) |=> store_q == $past(shift_q));

  a_r4_enable_off: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> chan_on == '0);

  a_r5_enter_mode: assert property (@(posedge clk) disable iff (!rst_n)
    enter_hit |=> diag_q);

  a_r7_all_on: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_q && !oe_n) |-> &chan_on);

  a_r8_diag_load: assert property (@(posedge clk) disable iff (!rst_n)
    (diag_q && le) |=> shift_q == $past(cap_q));

  a_r8_hold_still: assert property (@(posedge clk) disable iff (!rst_n)
    diag_q |=> $stable(store_q));

  a_r9_exit_mode: assert property (@(posedge clk) disable iff (!rst_n)
    exit_hit |=> !diag_q);

endmodule

bind led_sink_ctrl led_sink_ctrl_chk #(.W(CHANNELS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .le       (le),
  .oe_n     (oe_n),
  .sdo      (sdo),
  .chan_on  (chan_on),
  .diag_q   (diag_q),
  .enter_hit(enter_hit),
  .exit_hit (exit_hit),
  .shift_q  (shift_q),
  .store_q  (store_q),
  .cap_q    (cap_q)
);

// File: tb/led_sink_ctrl_tb.sv
module led_sink_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sdi = 1'b0;
  logic        le = 1'b0;
  logic        oe_n = 1'b0;
  logic [15:0] flt_open = 16'h8001;
  logic [15:0] flt_gnd  = 16'h0F00;
  logic [15:0] flt_sup  = 16'h00F0;
  logic        sdo;
  logic [15:0] chan_on;

  int checks = 0;
  int errors = 0;

  // Reference state kept from the requirements
  logic [15:0] m_shift = '0;
  logic [15:0] m_store = '0;
  logic [15:0] m_cap   = '0;
  logic        m_diag  = 1'b0;
  logic [1:0]  m_sel   = 2'b00;

  always #10 clk = ~clk;

  led_sink_ctrl u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .sdi     (sdi),
    .le      (le),
    .oe_n    (oe_n),
    .flt_open(flt_open),
    .flt_gnd (flt_gnd),
    .flt_sup (flt_sup),
    .sdo     (sdo),
    .chan_on (chan_on)
  );

  function automatic logic [15:0] want_flags(input logic [1:0] s);
    if (s == 2'b00) return flt_open;
    if (s == 2'b01) return flt_gnd;
    if (s == 2'b10) return flt_sup;
    return flt_open | flt_gnd | flt_sup;
  endfunction

  task automatic chk(input logic ok, input string req,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock edge with the given pin levels; returns at the falling edge
  task automatic step(input logic s, input logic o, input logic l);
    logic [15:0] old_shift;
    logic [15:0] old_cap;
    sdi = s; oe_n = o; le = l;
    @(posedge clk);
    old_shift = m_shift;
    old_cap   = m_cap;
    if (m_diag && !o) m_cap = want_flags(m_sel);
    if (l && m_diag) m_shift = old_cap;
    else m_shift = {old_shift[14:0], s};
    if (l && !m_diag) m_store = old_shift;
    @(negedge clk);
  endtask

  task automatic look_outputs(input string req);
    oe_n = 1'b1; #1;
    chk(chan_on == 16'h0, req, chan_on, 16'h0);
    oe_n = 1'b0; #1;
    chk(chan_on == (m_diag ? 16'hFFFF : m_store), req, chan_on,
        m_diag ? 16'hFFFF : m_store);
    oe_n = 1'b1;
  endtask

  task automatic t_reset;
    oe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(sdo == 1'b0, "R1 sdo in reset", {15'h0, sdo}, 16'h0);
    chk(chan_on == 16'h0, "R1 outputs off in reset", chan_on, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(chan_on == 16'h0, "R1 hold register clear", chan_on, 16'h0);
    oe_n = 1'b1;
  endtask

  task automatic t_load(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) step(w[i], 1'b1, 1'b0);
    chk(sdo == w[15], "R2 first bit on sdo after 16 edges", {15'h0, sdo}, {15'h0, w[15]});
    step(1'b0, 1'b1, 1'b1);
    chk(chan_on == 16'h0, "R4 enable high forces off", chan_on, 16'h0);
    oe_n = 1'b0; #1;
    chk(chan_on == w, "R3 latch copies chain", chan_on, w);
    oe_n = 1'b1;
    for (int i = 14; i >= 0; i--) begin
      chk(sdo == w[i], "R2 serial order", {15'h0, sdo}, {15'h0, w[i]});
      step(1'b0, 1'b1, 1'b0);
    end
  endtask

  task automatic t_pwm;
    for (int k = 0; k < 6; k++) begin
      logic o;
      o = k[0];
      oe_n = o; #1;
      chk(chan_on == (o ? 16'h0 : m_store), "R4 enable gating", chan_on,
          o ? 16'h0 : m_store);
      step(1'b0, o, 1'b0);
    end
    look_outputs("R4 hold kept across gating");
  endtask

  task automatic t_bad_seq;
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);  // wrong third step
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b0);
    look_outputs("R10 broken pattern stays normal");
    step(1'b1, 1'b1, 1'b1);
    look_outputs("R10 latch still active");
  endtask

  task automatic t_enter(input logic [1:0] s);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(s[1], 1'b1, 1'b1);
    step(s[0], 1'b1, 1'b0);
    m_diag = 1'b1;
    m_sel  = s;
    oe_n = 1'b0; #1;
    chk(chan_on == 16'hFFFF, "R5 R7 diagnostic all on", chan_on, 16'hFFFF);
    oe_n = 1'b1; #1;
    chk(chan_on == 16'h0, "R4 diagnostic enable high off", chan_on, 16'h0);
  endtask

  task automatic t_read(input logic [1:0] s);
    logic [15:0] got;
    step(1'b0, 1'b0, 1'b0);   // sample flags
    step(1'b0, 1'b1, 1'b1);   // load into chain
    for (int i = 15; i >= 0; i--) begin
      got[i] = sdo;
      step(1'b0, 1'b1, 1'b0);
    end
    chk(got == want_flags(s), "R6 R8 fault readback", got, want_flags(s));
  endtask

  task automatic t_exit;
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    m_diag = 1'b0;
    look_outputs("R8 R9 hold intact after exit");
    for (int i = 15; i >= 0; i--) step(i[0], 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    look_outputs("R9 latch works after exit");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_load(16'hA5C3);
    t_load(16'hFFFF);
    t_load(16'h0001);
    t_pwm();
    t_load(16'h3C5A);
    t_bad_seq();
    for (int m = 0; m < 4; m++) begin
      t_enter(m[1:0]);
      t_read(m[1:0]);
      t_exit();
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule